// File: doc/BRIEF.md
# Refresh-Driven Memory Map Selector

This block sits beside a Z80-style processor and chooses which of three memory maps decodes the processor's memory cycles: a startup map, a BASIC map and a CP/M map. The processor does not write a control register to change the map. Instead, the block watches the refresh cycles that follow every opcode fetch. On each one it captures bit 7 of the refresh address, which carries the top bit of the processor's refresh counter. Software switches maps with a counter load followed by a single-byte jump. The new counter bit only reaches the bus on the refresh after the jump's own fetch, so the jump is still fetched from the old map and its target is fetched from the new one.

Two configuration latches hold the state. The boot latch follows the captured bit 7; while it is set, the startup map is in force. The mode latch follows an output-port bit, where 0 means BASIC and 1 means CP/M. The mode latch counts only once the boot latch has returned to 0. Power-on reset forces both latches to 1. A lock input freezes both latches while the BASIC map is active. From the three top address lines and the current map, the block decodes a boot-ROM select, a BASIC-ROM select, a video-RAM select and a main-DRAM select with a bank number. It also drives a write-block strobe for the lowest DRAM bank in the BASIC map.

Top module: `memcfg_switch`

## Requirements
- R1: While `por_n` is 0, both latches read 1 asynchronously. Refresh cycles have no effect on them during reset, and the startup map applies.
- R2: On a rising `clk` edge where `mreq_n`=0, `rfsh_n`=0 and `m1_n`=1 (a refresh sample), the boot latch takes `ref_a7` and the mode latch takes `cpm_sel`. The new map decodes from the next cycle. No other cycle changes the latches: opcode fetch, a refresh with `m1_n`=0, or `rfsh_n`=0 with `mreq_n`=1.
- R3: Startup map (boot latch 1), where the address window is `mem_addr_top` = A15..A13:
  - 0000-3FFF selects `boot_rom_cs`.
  - 4000-7FFF selects `basic_rom_cs`.
  - 8000-BFFF selects `dram_cs` with bank 0.
  - C000-FFFF selects `vram_cs`.
- R4: BASIC map (boot latch 0, mode latch 0):
  - 0000-3FFF selects DRAM bank 0.
  - 4000-7FFF selects `vram_cs`, so pixel data sits at 4000.
  - 8000-BFFF selects DRAM bank 1.
  - C000-FFFF selects DRAM bank 2.
- R5: CP/M map (boot latch 0, mode latch 1):
  - 0000-3FFF selects DRAM bank 1.
  - 4000-7FFF selects DRAM bank 2.
  - 8000-BFFF selects DRAM bank 0.
  - C000-DFFF selects `vram_cs`.
  - E000-FFFF selects DRAM bank 0, which stands in for the upper half of video RAM.
- R6: `dram_ro_blk` is 1 exactly during a memory cycle with `wr_n`=0 to 0000-3FFF in the BASIC map, and 0 otherwise.
- R7: With `lock`=1 in the BASIC map, refresh samples leave both latches unchanged. In the startup and CP/M maps `lock` has no effect.
- R8: Power-on reset overrides `lock`. Asserting `por_n`=0 while locked in the BASIC map returns the block to the startup map.
- R9: During a memory cycle (`mreq_n`=0, `rfsh_n`=1) exactly one of the four selects is 1. Otherwise all selects are 0. `dram_bank` reads 0 whenever `dram_cs` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Processor clock |
| por_n | input | 1 | Asynchronous power-on reset, active low |
| mreq_n | input | 1 | Memory request, active low |
| rfsh_n | input | 1 | Refresh strobe, active low |
| m1_n | input | 1 | Opcode fetch marker, active low |
| wr_n | input | 1 | Write strobe, active low |
| mem_addr_top | input | 3 | Address lines A15..A13 |
| ref_a7 | input | 1 | Address line A7, the refresh counter's top bit during refresh |
| cpm_sel | input | 1 | Output-port bit: 0 BASIC, 1 CP/M |
| lock | input | 1 | Freezes the latches in the BASIC map |
| boot_rom_cs | output | 1 | Boot EPROM select |
| basic_rom_cs | output | 1 | BASIC EPROM select |
| vram_cs | output | 1 | Video DRAM select |
| dram_cs | output | 1 | Main DRAM select |
| dram_bank | output | 2 | Main DRAM bank number (0..2) |
| dram_ro_blk | output | 1 | Write-block strobe for DRAM bank 0 in the BASIC map |

## Verification
The selects and the write-block strobe are combinational in the current cycle's address and strobes. The bench therefore compares them one time unit after the falling edge on which it drives new inputs. A map change needs one register: it appears at the first falling-edge comparison after the rising edge that saw the refresh sample. The reference model updates its latch copy only after that rising edge. The reset case is the exception, because reset acts asynchronously. The model applies it the moment `por_n` is driven low, and the design must already show the startup map at that same falling-edge comparison.

// File: rtl/memcfg_pkg.sv
package memcfg_pkg;

  typedef enum logic [1:0] {
    MAP_BOOT  = 2'd0,
    MAP_BASIC = 2'd1,
    MAP_CPM   = 2'd2
  } map_e;

  typedef struct packed {
    logic       boot_rom;
    logic       basic_rom;
    logic       vram;
    logic       dram;
    logic [1:0] bank;
  } sel_t;

  localparam sel_t SEL_NONE = '{boot_rom: 1'b0, basic_rom: 1'b0, vram: 1'b0, dram: 1'b0, bank: 2'd0};

  // Map in force for a given pair of latch values.
  function automatic map_e map_of(input logic boot_q, input logic cpm_q);
    if (boot_q)      return MAP_BOOT;
    else if (cpm_q)  return MAP_CPM;
    else             return MAP_BASIC;
  endfunction

  // DRAM select for a bank number.
  function automatic sel_t dram_sel(input logic [1:0] bank);
    sel_t s;
    s      = SEL_NONE;
    s.dram = 1'b1;
    s.bank = bank;
    return s;
  endfunction

  // Address decode for one memory cycle: quad = A15..A14, half = A13.
  function automatic sel_t decode(input map_e m, input logic [1:0] quad, input logic half);
    sel_t s;
    s = SEL_NONE;
    unique case (m)
      MAP_BOOT: begin
        unique case (quad)
          2'd0: s.boot_rom  = 1'b1;
          2'd1: s.basic_rom = 1'b1;
          2'd2: s           = dram_sel(2'd0);
          default: s.vram   = 1'b1;
        endcase
      end
      MAP_BASIC: begin
        unique case (quad)
          2'd0: s         = dram_sel(2'd0);
          2'd1: s.vram    = 1'b1;
          2'd2: s         = dram_sel(2'd1);
          default: s      = dram_sel(2'd2);
        endcase
      end
      default: begin
        unique case (quad)
          2'd0: s = dram_sel(2'd1);
          2'd1: s = dram_sel(2'd2);
          2'd2: s = dram_sel(2'd0);
          default: begin
            if (half) s = dram_sel(2'd0);
            else      s.vram = 1'b1;
          end
        endcase
      end
    endcase
    return s;
  endfunction

  // Write-block condition for the lowest DRAM bank.
  function automatic logic ro_hit(input map_e m, input logic [1:0] quad, input logic is_write);
    return (m == MAP_BASIC) && (quad == 2'd0) && is_write;
  endfunction

endpackage

// File: rtl/memcfg_cycle_qual.sv
module memcfg_cycle_qual (
  input  logic mreq_n,
  input  logic rfsh_n,
  input  logic m1_n,
  output logic mem_cyc,
  output logic rfsh_smp
);
  // Ordinary memory access: request active, refresh idle.
  assign mem_cyc  = !mreq_n && rfsh_n;
  // Refresh address valid: request and refresh active, fetch marker idle.
  assign rfsh_smp = !mreq_n && !rfsh_n && m1_n;
endmodule

// File: rtl/memcfg_state.sv
module memcfg_state (
  input  logic clk,
  input  logic por_n,
  input  logic smp,
  input  logic hold,
  input  logic a_bit,
  input  logic mode_bit,
  output logic boot_q,
  output logic cpm_q
);
  logic take;
  assign take = smp && !hold;

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      boot_q <= 1'b1;
      cpm_q  <= 1'b1;
    end else if (take) begin
      boot_q <= a_bit;
      cpm_q  <= mode_bit;
    end
  end
endmodule

// File: rtl/memcfg_decode.sv
module memcfg_decode
  import memcfg_pkg::*;
#(
  parameter int TOP_W = 3
) (
  input  map_e             cur_map,
  input  logic [TOP_W-1:0] addr_top,
  input  logic             mem_cyc,
  input  logic             wr_n,
  output sel_t             sel,
  output logic             ro_blk
);
  localparam int QUAD_HI = TOP_W - 1;
  localparam int QUAD_LO = TOP_W - 2;
  localparam int HALF_B  = TOP_W - 3;

  logic [1:0] quad;
  logic       half;
  assign quad = addr_top[QUAD_HI:QUAD_LO];
  assign half = addr_top[HALF_B];

  always_comb begin
    sel    = SEL_NONE;
    ro_blk = 1'b0;
    if (mem_cyc) begin
      sel    = decode(cur_map, quad, half);
      ro_blk = ro_hit(cur_map, quad, !wr_n);
    end
  end
endmodule

// File: rtl/memcfg_switch.sv
module memcfg_switch
  import memcfg_pkg::*;
#(
  parameter int TOP_W = 3
) (
  input  logic             clk,
  input  logic             por_n,
  input  logic             mreq_n,
  input  logic             rfsh_n,
  input  logic             m1_n,
  input  logic             wr_n,
  input  logic [TOP_W-1:0] mem_addr_top,
  input  logic             ref_a7,
  input  logic             cpm_sel,
  input  logic             lock,
  output logic             boot_rom_cs,
  output logic             basic_rom_cs,
  output logic             vram_cs,
  output logic             dram_cs,
  output logic [1:0]       dram_bank,
  output logic             dram_ro_blk
);
  // Named internal events for the checker.
  logic mem_cyc;
  logic rfsh_smp;
  logic cfg_boot;
  logic cfg_cpm;
  logic lock_hold;
  map_e cur_map;
  sel_t sel;

  memcfg_cycle_qual u_qual (
    .mreq_n  (mreq_n),
    .rfsh_n  (rfsh_n),
    .m1_n    (m1_n),
    .mem_cyc (mem_cyc),
    .rfsh_smp(rfsh_smp)
  );

  assign cur_map   = map_of(cfg_boot, cfg_cpm);
  assign lock_hold = lock && (cur_map == MAP_BASIC);

  memcfg_state u_state (
    .clk     (clk),
    .por_n   (por_n),
    .smp     (rfsh_smp),
    .hold    (lock_hold),
    .a_bit   (ref_a7),
    .mode_bit(cpm_sel),
    .boot_q  (cfg_boot),
    .cpm_q   (cfg_cpm)
  );

  memcfg_decode #(.TOP_W(TOP_W)) u_dec (
    .cur_map (cur_map),
    .addr_top(mem_addr_top),
    .mem_cyc (mem_cyc),
    .wr_n    (wr_n),
    .sel     (sel),
    .ro_blk  (dram_ro_blk)
  );

  assign boot_rom_cs  = sel.boot_rom;
  assign basic_rom_cs = sel.basic_rom;
  assign vram_cs      = sel.vram;
  assign dram_cs      = sel.dram;
  assign dram_bank    = sel.bank;
endmodule

// File: rtl/memcfg_switch_chk.sv
module memcfg_switch_chk (
  input logic       clk,
  input logic       por_n,
  input logic       mreq_n,
  input logic       rfsh_n,
  input logic       m1_n,
  input logic       wr_n,
  input logic       ref_a7,
  input logic       cpm_sel,
  input logic       lock,
  input logic       cfg_boot,
  input logic       cfg_cpm,
  input logic       boot_rom_cs,
  input logic       basic_rom_cs,
  input logic       vram_cs,
  input logic       dram_cs,
  input logic [1:0] dram_bank,
  input logic       dram_ro_blk
);
  logic [3:0] sels;
  logic       in_basic;
  logic       smp_pins;
  assign sels     = {boot_rom_cs, basic_rom_cs, vram_cs, dram_cs};
  assign in_basic = !cfg_boot && !cfg_cpm;
  assign smp_pins = !mreq_n && !rfsh_n && m1_n;

  // R1: reset holds the startup state
  always_ff @(posedge clk) begin
    if (!por_n) a_r1_reset_startup: assert (cfg_boot && cfg_cpm);
  end

  a_r2_stable_without_sample: assert property (@(posedge clk) disable iff (!por_n)
    !smp_pins |=> $stable({cfg_boot, cfg_cpm}));

  a_r2_capture: assert property (@(posedge clk) disable iff (!por_n)
    (smp_pins && !(lock && in_basic)) |=> (cfg_boot == $past(ref_a7)) && (cfg_cpm == $past(cpm_sel)));

  a_r7_lock_freeze: assert property (@(posedge clk) disable iff (!por_n)
    (lock && in_basic) |=> $stable({cfg_boot, cfg_cpm}));

  a_r6_ro_only_basic_write: assert property (@(posedge clk) disable iff (!por_n)
    dram_ro_blk |-> (in_basic && !wr_n && dram_cs && (dram_bank == 2'd0)));

  a_r9_one_select: assert property (@(posedge clk) disable iff (!por_n)
    (!mreq_n && rfsh_n) |-> ($countones(sels) == 1));

  a_r9_idle_quiet: assert property (@(posedge clk) disable iff (!por_n)
    !(!mreq_n && rfsh_n) |-> (sels == 4'd0 && !dram_ro_blk));

  a_r9_bank_zero: assert property (@(posedge clk) disable iff (!por_n)
    !dram_cs |-> (dram_bank == 2'd0));
endmodule

bind memcfg_switch memcfg_switch_chk u_chk (
  .clk         (clk),
  .por_n       (por_n),
  .mreq_n      (mreq_n),
  .rfsh_n      (rfsh_n),
  .m1_n        (m1_n),
  .wr_n        (wr_n),
  .ref_a7      (ref_a7),
  .cpm_sel     (cpm_sel),
  .lock        (lock),
  .cfg_boot    (cfg_boot),
  .cfg_cpm     (cfg_cpm),
  .boot_rom_cs (boot_rom_cs),
  .basic_rom_cs(basic_rom_cs),
  .vram_cs     (vram_cs),
  .dram_cs     (dram_cs),
  .dram_bank   (dram_bank),
  .dram_ro_blk (dram_ro_blk)
);

// File: tb/test_memcfg_switch.sv
module test_memcfg_switch;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       por_n = 1'b1;
  logic       mreq_n = 1'b1, rfsh_n = 1'b1, m1_n = 1'b1, wr_n = 1'b1;
  logic [2:0] mem_addr_top = 3'd0;
  logic       ref_a7 = 1'b0, cpm_sel = 1'b0, lock = 1'b0;
  logic       boot_rom_cs, basic_rom_cs, vram_cs, dram_cs, dram_ro_blk;
  logic [1:0] dram_bank;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;
  // reference state
  int m_boot = 1;
  int m_cpm  = 1;

  always #(CLK_PERIOD/2) clk = ~clk;

  memcfg_switch i_memcfg_switch (
    .clk(clk), .por_n(por_n), .mreq_n(mreq_n), .rfsh_n(rfsh_n), .m1_n(m1_n),
    .wr_n(wr_n), .mem_addr_top(mem_addr_top), .ref_a7(ref_a7), .cpm_sel(cpm_sel),
    .lock(lock), .boot_rom_cs(boot_rom_cs), .basic_rom_cs(basic_rom_cs),
    .vram_cs(vram_cs), .dram_cs(dram_cs), .dram_bank(dram_bank), .dram_ro_blk(dram_ro_blk)
  );

  // Expected {boot, basic, vram, dram, bank[1:0], ro} from the address range.
  function automatic logic [6:0] expect_out(int b, int c, logic mq, logic rf, logic wr, logic [2:0] top);
    int a = int'(top) * 8192;
    logic [6:0] e = 7'd0;
    if (mq || !rf) return 7'd0;
    if (b != 0) begin
      if (a < 'h4000)      e = 7'b1000000;
      else if (a < 'h8000) e = 7'b0100000;
      else if (a < 'hC000) e = 7'b0001000;
      else                 e = 7'b0010000;
    end else if (c == 0) begin
      if (a < 'h4000)      e = {6'b000100, !wr};
      else if (a < 'h8000) e = 7'b0010000;
      else if (a < 'hC000) e = 7'b0001010;
      else                 e = 7'b0001100;
    end else begin
      if (a < 'h4000)      e = 7'b0001010;
      else if (a < 'h8000) e = 7'b0001100;
      else if (a < 'hC000) e = 7'b0001000;
      else if (a < 'hE000) e = 7'b0010000;
      else                 e = 7'b0001000;
    end
    return e;
  endfunction

  task automatic step(input logic mq, input logic rf, input logic m1, input logic wr,
                      input logic [2:0] top, input logic a7, input logic cp, input logic lk,
                      input string tag);
    logic [6:0] act, exp_v;
    @(negedge clk);
    mreq_n = mq; rfsh_n = rf; m1_n = m1; wr_n = wr;
    mem_addr_top = top; ref_a7 = a7; cpm_sel = cp; lock = lk;
    if (!por_n) begin m_boot = 1; m_cpm = 1; end
    #1;
    act   = {boot_rom_cs, basic_rom_cs, vram_cs, dram_cs, dram_bank, dram_ro_blk};
    exp_v = expect_out(m_boot, m_cpm, mq, rf, wr, top);
    checks++;
    if (act !== exp_v) begin
      fails++;
      $display("FAIL %s: actual %b expected %b (top=%0d)", tag, act, exp_v, top);
    end
    @(posedge clk);
    if (!por_n) begin
      m_boot = 1; m_cpm = 1;
    end else if (!mq && !rf && m1 && !(lk && m_boot == 0 && m_cpm == 0)) begin
      m_boot = int'(a7); m_cpm = int'(cp);
    end
  endtask

  task automatic sweep(input logic lk, input string tag);
    for (int t = 0; t < 8; t++) begin
      step(1'b0, 1'b1, 1'b1, 1'b1, 3'(t), 1'b0, 1'b0, lk, tag);
      step(1'b0, 1'b1, 1'b1, 1'b0, 3'(t), 1'b0, 1'b0, lk, tag);
    end
  endtask

  // refresh sample helper
  task automatic refresh(input logic a7, input logic cp, input logic lk, input string tag);
    step(1'b0, 1'b0, 1'b1, 1'b1, 3'd0, a7, cp, lk, tag);
  endtask

  initial begin
    #2 por_n = 1'b0;
    step(1'b0, 1'b1, 1'b1, 1'b1, 3'd0, 1'b0, 1'b0, 1'b0, "R1 reset startup");
    refresh(1'b0, 1'b0, 1'b0, "R1 refresh during reset");
    step(1'b0, 1'b1, 1'b1, 1'b1, 3'd2, 1'b0, 1'b0, 1'b0, "R1 still startup");
    @(negedge clk); por_n = 1'b1;

    sweep(1'b0, "R3 startup decode");
    step(1'b1, 1'b1, 1'b1, 1'b1, 3'd0, 1'b0, 1'b0, 1'b0, "R9 idle no select");
    refresh(1'b1, 1'b0, 1'b0, "R9 refresh no select");

    // fetch of the jump, then non-qualifying strobes
    step(1'b0, 1'b1, 1'b0, 1'b1, 3'd0, 1'b0, 1'b0, 1'b0, "R2 fetch from old map");
    step(1'b0, 1'b0, 1'b0, 1'b1, 3'd0, 1'b0, 1'b0, 1'b0, "R2 refresh with m1 low");
    step(1'b1, 1'b0, 1'b1, 1'b1, 3'd0, 1'b0, 1'b0, 1'b0, "R2 rfsh without mreq");
    step(1'b0, 1'b1, 1'b1, 1'b1, 3'd0, 1'b0, 1'b0, 1'b0, "R2 map unchanged");

    // switch to BASIC
    refresh(1'b0, 1'b0, 1'b0, "R2 switch sample");
    sweep(1'b0, "R4 R6 basic decode");

    // lock in BASIC
    refresh(1'b1, 1'b0, 1'b1, "R7 locked sample a7=1");
    step(1'b0, 1'b1, 1'b1, 1'b0, 3'd0, 1'b0, 1'b0, 1'b1, "R7 still basic");
    refresh(1'b0, 1'b1, 1'b1, "R7 locked sample cpm");
    sweep(1'b1, "R7 basic kept");

    // reset beats the lock
    @(negedge clk); por_n = 1'b0;
    step(1'b0, 1'b1, 1'b1, 1'b1, 3'd0, 1'b0, 1'b0, 1'b1, "R8 reset over lock");
    step(1'b0, 1'b1, 1'b1, 1'b1, 3'd6, 1'b0, 1'b0, 1'b1, "R8 startup after reset");
    @(negedge clk); por_n = 1'b1;

    // lock ignored in startup, go to CP/M
    refresh(1'b0, 1'b1, 1'b1, "R7 lock ignored startup");
    sweep(1'b1, "R5 cpm decode");
    refresh(1'b1, 1'b0, 1'b1, "R7 lock ignored cpm");
    step(1'b0, 1'b1, 1'b1, 1'b1, 3'd0, 1'b0, 1'b0, 1'b1, "R7 back to startup");
    refresh(1'b0, 1'b0, 1'b0, "R2 to basic");
    step(1'b0, 1'b1, 1'b1, 1'b0, 3'd1, 1'b0, 1'b0, 1'b0, "R6 no block at 4000");
    refresh(1'b1, 1'b0, 1'b0, "R2 to startup");
    step(1'b0, 1'b1, 1'b1, 1'b0, 3'd0, 1'b0, 1'b0, 1'b0, "R6 no block startup");

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 20000);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end
endmodule